// File: doc/BRIEF.md
# Multi-Bank Page Manager

The page manager sits between a request decoder and a transfer stage of a synchronous DRAM controller. Each accepted request names a bank (one of four), a row, a column, a direction and a close flag. The block remembers which row, if any, is open in every bank. From that it decides whether the request is a page hit, a page miss on an open bank, or an access to a closed bank. It then issues the required precharge and activate commands and finally the read or write. Every command appears on a single-cycle output as a 2-bit code with its bank and address.

Each bank runs its own state machine with two countdown timers. One timer spaces commands after a precharge (row precharge time) or an activate (row-to-column time). The other timer holds off any precharge until the row-active time has run out. The states are IDLE, PRE, ACT, XFER and CLOSE. The transitions are: IDLE→XFER on a hit, IDLE→PRE on a miss, IDLE→ACT on a closed bank, PRE→ACT and ACT→XFER when their command is granted, XFER→CLOSE when the close flag is set and XFER→IDLE otherwise, and CLOSE→IDLE once its precharge is granted. Up to four banks may hold requests at once, capped by a depth setting. When several banks are ready in the same cycle, the lowest-numbered bank wins. A refresh pulse from downstream marks every bank closed.

Top module: `bank_page_mgr`

## Requirements
- R1: A request whose bank holds the same row open (page hit) issues only its read (code 2) or write (code 3), with the column on `out_addr`.
- R2: A request to a closed bank issues activate (code 1) with the row on `out_addr`, then its read or write.
- R3: A request to a bank with a different row open issues precharge (code 0, address 0), then activate, then read or write.
- R4: A request with `in_close` set is followed by a precharge of its bank after the read or write, leaving the bank closed.
- R5: A read or write issues no earlier than `cfg_trcd`+1 cycles after the activate of its bank, and exactly then when the ready flags allow.
- R6: An activate issues no earlier than `cfg_trp`+1 cycles after a precharge of the same bank.
- R7: A precharge issues no earlier than `cfg_tras`+1 cycles after the activate of the same bank.
- R8: `in_ready` is high only when the addressed bank holds no request and fewer than `cfg_depth`+1 requests are held in total.
- R9: Precharge of bank b requires `pre_ok[b]`; activate requires `act_ok`; read requires `rd_ok`; write requires `wr_ok`. Without its flag, a command waits.
- R10: At most one command issues per cycle. Among banks ready in the same cycle, the lowest-numbered bank is granted.
- R11: A `refresh` pulse, allowed only while no request is held, marks all banks closed, so the next request to any bank starts with an activate.
- R12: After reset, no bank is open, no request is held, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_depth | input | 2 | Maximum held requests minus one |
| cfg_tras | input | 4 | Row-active time, cycles |
| cfg_trp | input | 4 | Row precharge time, cycles |
| cfg_trcd | input | 4 | Row-to-column time, cycles |
| in_valid | input | 1 | Request present |
| in_bank | input | 2 | Request bank |
| in_row | input | ROW_W | Request row |
| in_col | input | COL_W | Request column |
| in_write | input | 1 | 1 = write, 0 = read |
| in_close | input | 1 | Close the bank after this transfer |
| in_ready | output | 1 | Request accepted this cycle when valid |
| refresh | input | 1 | Downstream refresh, closes all banks |
| pre_ok | input | 4 | Per-bank precharge permission |
| act_ok | input | 1 | Activate permission |
| rd_ok | input | 1 | Read permission |
| wr_ok | input | 1 | Write permission |
| out_valid | output | 1 | Command issued this cycle |
| out_cmd | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| out_bank | output | 2 | Command bank |
| out_addr | output | ADDR_W | Row for activate, column for read/write, 0 for precharge |

## Verification
A table of requests walks the three page outcomes: hit, miss on an open row, and access to a closed bank, with and without the close flag. This shows whether the open-row record is kept correctly from request to request, and the spacing of each command sequence is measured against the three timing settings. Four closed banks are then released together, which separates the fixed-priority order from any fair rotation: bank 3's activate must lose to the reads of banks 0 to 2. Further directed runs withhold each ready flag in turn, lower the depth, and refresh while banks are open. These show that each flag gates only its own command, that the cap counts held requests, and that refresh forgets open rows.

// File: rtl/pgm_pkg.sv
`timescale 1ns/1ps
package pgm_pkg;
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);
    localparam int TMR_W  = 4;
    localparam int AGE_W  = TMR_W + 1;

    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } cmd_t;

    typedef enum logic [2:0] {
        B_IDLE,
        B_PRE,
        B_ACT,
        B_XFER,
        B_CLOSE
    } bst_t;
endpackage

// File: rtl/pgm_bank.sv
`timescale 1ns/1ps
module pgm_bank
    import pgm_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  cfg_tras,
    input  logic [TMR_W-1:0]  cfg_trp,
    input  logic [TMR_W-1:0]  cfg_trcd,
    input  logic              acc,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic [COL_W-1:0]  acc_col,
    input  logic              acc_wr,
    input  logic              acc_close,
    input  logic              refresh,
    input  logic              pre_ok,
    input  logic              act_ok,
    input  logic              rd_ok,
    input  logic              wr_ok,
    input  logic              grant,
    output logic              idle,
    output logic              want,
    output cmd_t              want_cmd,
    output logic [ADDR_W-1:0] want_addr
);
    bst_t               state, state_n;
    logic               open_q;
    logic [ROW_W-1:0]   open_row;
    logic [ROW_W-1:0]   row_q;
    logic [COL_W-1:0]   col_q;
    logic               wr_q, close_q;
    logic [TMR_W-1:0]   nxt_tmr, ras_tmr;
    logic               hit;

    assign hit  = open_q && !refresh && (open_row == acc_row);
    assign idle = (state == B_IDLE);

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            B_IDLE:  if (acc) state_n = hit ? B_XFER : (open_q && !refresh) ? B_PRE : B_ACT;
            B_PRE:   if (grant) state_n = B_ACT;
            B_ACT:   if (grant) state_n = B_XFER;
            B_XFER:  if (grant) state_n = close_q ? B_CLOSE : B_IDLE;
            B_CLOSE: if (grant) state_n = B_IDLE;
            default: state_n = B_IDLE;
        endcase
    end

    // state register, timers and held request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= B_IDLE;
            open_q   <= 1'b0;
            open_row <= '0;
            row_q    <= '0;
            col_q    <= '0;
            wr_q     <= 1'b0;
            close_q  <= 1'b0;
            nxt_tmr  <= '0;
            ras_tmr  <= '0;
        end else begin
            state <= state_n;
            if (nxt_tmr != '0) nxt_tmr <= nxt_tmr - 1'b1;
            if (ras_tmr != '0) ras_tmr <= ras_tmr - 1'b1;
            if (acc) begin
                row_q   <= acc_row;
                col_q   <= acc_col;
                wr_q    <= acc_wr;
                close_q <= acc_close;
            end
            if (refresh) open_q <= 1'b0;
            if (grant) begin
                unique case (state)
                    B_PRE, B_CLOSE: begin
                        open_q  <= 1'b0;
                        nxt_tmr <= cfg_trp;
                    end
                    B_ACT: begin
                        open_q   <= 1'b1;
                        open_row <= row_q;
                        nxt_tmr  <= cfg_trcd;
                        ras_tmr  <= cfg_tras;
                    end
                    default: ;
                endcase
            end
        end
    end

    // command request towards the picker
    always_comb begin
        want      = 1'b0;
        want_cmd  = CMD_PRE;
        want_addr = '0;
        unique case (state)
            B_IDLE: ;
            B_PRE, B_CLOSE: begin
                want = (ras_tmr == '0) && pre_ok;
            end
            B_ACT: begin
                want      = (nxt_tmr == '0) && act_ok;
                want_cmd  = CMD_ACT;
                want_addr = ADDR_W'(row_q);
            end
            B_XFER: begin
                want      = (nxt_tmr == '0) && (wr_q ? wr_ok : rd_ok);
                want_cmd  = wr_q ? CMD_WR : CMD_RD;
                want_addr = ADDR_W'(col_q);
            end
            default: ;
        endcase
    end

    // elapsed-cycle monitors for timing assertions
    logic [AGE_W-1:0] act_age, pre_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_age <= '1;
            pre_age <= '1;
        end else begin
            if (grant && state == B_ACT) act_age <= '0;
            else if (act_age != '1)      act_age <= act_age + 1'b1;
            if (grant && (state == B_PRE || state == B_CLOSE)) pre_age <= '0;
            else if (pre_age != '1)                            pre_age <= pre_age + 1'b1;
        end
    end

    a_r5_trcd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && state == B_XFER) |-> (act_age >= {1'b0, cfg_trcd}));
    a_r6_trp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && state == B_ACT) |-> (pre_age >= {1'b0, cfg_trp}));
    a_r7_tras_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (state == B_PRE || state == B_CLOSE)) |-> (act_age >= {1'b0, cfg_tras}));
    a_r9_grant_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> want);
    a_r4_close_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && state == B_XFER && close_q) |=> (state == B_CLOSE));
endmodule

// File: rtl/pgm_pick.sv
`timescale 1ns/1ps
module pgm_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // lowest index wins
    assign gnt = req & (~req + 1'b1);
endmodule

// File: rtl/bank_page_mgr.sv
`timescale 1ns/1ps
module bank_page_mgr
    import pgm_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 10,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_depth,
    input  logic [3:0]        cfg_tras,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trcd,
    input  logic              in_valid,
    input  logic [1:0]        in_bank,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic              in_write,
    input  logic              in_close,
    output logic              in_ready,
    input  logic              refresh,
    input  logic [3:0]        pre_ok,
    input  logic              act_ok,
    input  logic              rd_ok,
    input  logic              wr_ok,
    output logic              out_valid,
    output logic [1:0]        out_cmd,
    output logic [1:0]        out_bank,
    output logic [ADDR_W-1:0] out_addr
);
    logic [NBANK-1:0]  idle, want, grant, acc;
    cmd_t              w_cmd  [NBANK];
    logic [ADDR_W-1:0] w_addr [NBANK];
    logic [BANK_W:0]   held_cnt;

    always_comb begin
        held_cnt = '0;
        for (int i = 0; i < NBANK; i++)
            held_cnt = held_cnt + {{BANK_W{1'b0}}, ~idle[i]};
    end

    assign in_ready = idle[in_bank] && (held_cnt <= {1'b0, cfg_depth});

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign acc[b] = in_valid && in_ready && (in_bank == BANK_W'(b));
        pgm_bank #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_tras  (cfg_tras),
            .cfg_trp   (cfg_trp),
            .cfg_trcd  (cfg_trcd),
            .acc       (acc[b]),
            .acc_row   (in_row),
            .acc_col   (in_col),
            .acc_wr    (in_write),
            .acc_close (in_close),
            .refresh   (refresh),
            .pre_ok    (pre_ok[b]),
            .act_ok    (act_ok),
            .rd_ok     (rd_ok),
            .wr_ok     (wr_ok),
            .grant     (grant[b]),
            .idle      (idle[b]),
            .want      (want[b]),
            .want_cmd  (w_cmd[b]),
            .want_addr (w_addr[b])
        );
    end

    pgm_pick #(.N(NBANK)) u_pick (
        .req (want),
        .gnt (grant)
    );

    always_comb begin
        out_valid = |grant;
        out_cmd   = CMD_PRE;
        out_bank  = '0;
        out_addr  = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (grant[i]) begin
                out_cmd  = w_cmd[i];
                out_bank = BANK_W'(i);
                out_addr = w_addr[i];
            end
        end
    end

    a_r8_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~idle) <= int'(cfg_depth) + 1);
    a_r10_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((want & ((4'd1 << out_bank) - 4'd1)) == 4'd0));
    a_r11_refresh_idle: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> (&idle));
    a_r12_no_cmd_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/bank_page_mgr_bench.sv
`timescale 1ns/1ps
module bank_page_mgr_bench;
    localparam int TRAS = 6, TRP = 2, TRCD = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  cfg_depth = 2'd3;
    logic [3:0]  cfg_tras = 4'(TRAS), cfg_trp = 4'(TRP), cfg_trcd = 4'(TRCD);
    logic        in_valid = 1'b0;
    logic [1:0]  in_bank = '0;
    logic [11:0] in_row = '0;
    logic [9:0]  in_col = '0;
    logic        in_write = 1'b0, in_close = 1'b0, in_ready;
    logic        refresh = 1'b0;
    logic [3:0]  pre_ok = 4'hF;
    logic        act_ok = 1'b1, rd_ok = 1'b1, wr_ok = 1'b1;
    logic        out_valid;
    logic [1:0]  out_cmd, out_bank;
    logic [11:0] out_addr;

    always #2.5 clk = ~clk;

    bank_page_mgr u_bank_page_mgr (.*);

    int n_chk = 0, n_err = 0, cyc = 0, ln = 0;
    int lc [256], lb [256], la [256], lt [256];

    always @(posedge clk) cyc++;
    always @(negedge clk) if (rst_n && out_valid && ln < 256) begin
        lc[ln] = out_cmd; lb[ln] = out_bank; la[ln] = out_addr; lt[ln] = cyc; ln++;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic try_send(int b, int row, int col, bit wr, bit cl, output bit ok);
        @(negedge clk);
        in_valid = 1'b1; in_bank = 2'(b); in_row = 12'(row); in_col = 10'(col);
        in_write = wr; in_close = cl;
        #1 ok = in_ready;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send(int b, int row, int col, bit wr, bit cl);
        bit ok = 1'b0;
        while (!ok) try_send(b, row, col, wr, cl, ok);
    endtask

    task automatic pulse_refresh();
        @(negedge clk); refresh = 1'b1;
        @(negedge clk); refresh = 1'b0;
    endtask

    // {bank[12:11], row[10:7], col[6:2], write[1], close[0]}
    localparam logic [12:0] VEC [8] = '{
        {2'd0, 4'd5, 5'd1, 1'b0, 1'b0},
        {2'd0, 4'd5, 5'd2, 1'b1, 1'b0},
        {2'd0, 4'd7, 5'd3, 1'b0, 1'b0},
        {2'd1, 4'd2, 5'd4, 1'b1, 1'b1},
        {2'd1, 4'd2, 5'd5, 1'b0, 1'b0},
        {2'd2, 4'd9, 5'd6, 1'b0, 1'b1},
        {2'd0, 4'd7, 5'd7, 1'b1, 1'b1},
        {2'd3, 4'd1, 5'd0, 1'b0, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit m_open [4] = '{default: 1'b0};
        int m_row [4];
        bit ok;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R12 in_ready after reset", in_ready, 1);
        chk("R12 out_valid after reset", out_valid, 0);

        // table walk: hit / miss / closed, with and without close
        foreach (VEC[v]) begin
            int b, row, col, n, ia;
            bit wr, cl;
            int ec [4], ea [4];
            string tag;
            b = VEC[v][12:11]; row = VEC[v][10:7]; col = VEC[v][6:2];
            wr = VEC[v][1]; cl = VEC[v][0];
            n = 0; ia = -1;
            if (m_open[b] && m_row[b] == row) tag = "R1";
            else begin
                if (m_open[b]) begin tag = "R3"; ec[n] = 0; ea[n] = 0; n++; end
                else tag = "R2";
                ia = n; ec[n] = 1; ea[n] = row; n++;
            end
            ec[n] = wr ? 3 : 2; ea[n] = col; n++;
            if (cl) begin ec[n] = 0; ea[n] = 0; n++; m_open[b] = 1'b0; end
            else begin m_open[b] = 1'b1; m_row[b] = row; end
            base = ln;
            send(b, row, col, wr, cl);
            repeat (30) @(negedge clk);
            chk({tag, " command count"}, ln - base, n);
            if (ln - base == n) begin
                for (int i = 0; i < n; i++) begin
                    chk({(cl && i == n-1) ? "R4" : tag, " cmd"}, lc[base+i], ec[i]);
                    chk({tag, " bank"}, lb[base+i], b);
                    chk({tag, " addr"}, la[base+i], ea[i]);
                end
                if (ia > 0) chk("R6 trp gap", lt[base+ia] - lt[base+ia-1], TRP + 1);
                if (ia >= 0) chk("R5 trcd gap", lt[base+ia+1] - lt[base+ia], TRCD + 1);
                if (ia >= 0 && cl)
                    chk("R7 tras gap", lt[base+n-1] - lt[base+ia],
                        (TRAS + 1 > TRCD + 2) ? TRAS + 1 : TRCD + 2);
            end
        end

        // refresh forgets the open row of bank 3
        pulse_refresh();
        base = ln;
        send(3, 1, 0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk("R11 count after refresh", ln - base, 2);
        chk("R11 activate after refresh", lc[base], 1);

        // fixed priority: four banks released together
        pulse_refresh();
        act_ok = 1'b0;
        base = ln;
        try_send(3, 4, 0, 1'b0, 1'b0, ok); chk("R8 accept bank3", ok, 1);
        try_send(1, 4, 0, 1'b0, 1'b0, ok); chk("R8 accept bank1", ok, 1);
        try_send(2, 4, 0, 1'b0, 1'b0, ok); chk("R8 accept bank2", ok, 1);
        try_send(0, 4, 0, 1'b0, 1'b0, ok); chk("R8 accept bank0", ok, 1);
        try_send(2, 5, 0, 1'b0, 1'b0, ok); chk("R8 busy bank refused", ok, 0);
        chk("R9 activate held without act_ok", ln - base, 0);
        act_ok = 1'b1;
        repeat (30) @(negedge clk);
        chk("R10 count", ln - base, 8);
        if (ln - base == 8) begin
            int pc [8] = '{1, 1, 1, 2, 2, 2, 1, 2};
            int pb [8] = '{0, 1, 2, 0, 1, 2, 3, 3};
            int pt [8] = '{0, 1, 2, 3, 4, 5, 6, 9};
            for (int i = 0; i < 8; i++) begin
                chk("R10 order cmd", lc[base+i], pc[i]);
                chk("R10 order bank", lb[base+i], pb[i]);
                chk("R10 order cycle", lt[base+i] - lt[base], pt[i]);
            end
        end

        // depth cap and read/write flags
        cfg_depth = 2'd1;
        rd_ok = 1'b0;
        base = ln;
        try_send(0, 4, 1, 1'b0, 1'b0, ok); chk("R8 depth accept 1", ok, 1);
        try_send(1, 4, 2, 1'b0, 1'b0, ok); chk("R8 depth accept 2", ok, 1);
        try_send(2, 4, 3, 1'b0, 1'b0, ok); chk("R8 depth refused", ok, 0);
        repeat (5) @(negedge clk);
        chk("R9 read held without rd_ok", ln - base, 0);
        rd_ok = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 reads after rd_ok", ln - base, 2);
        if (ln - base == 2) begin
            chk("R1 read cmd", lc[base], 2);
            chk("R1 read addr", la[base+1], 2);
        end
        wr_ok = 1'b0;
        base = ln;
        send(2, 4, 3, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        chk("R9 write held without wr_ok", ln - base, 0);
        wr_ok = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 write after wr_ok", ln - base, 1);
        chk("R9 write cmd", lc[base], 3);

        // per-bank precharge permission on a miss
        pre_ok = 4'b1110;
        base = ln;
        send(0, 8, 9, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        chk("R9 precharge held without pre_ok", ln - base, 0);
        pre_ok = 4'hF;
        repeat (20) @(negedge clk);
        chk("R3 miss count", ln - base, 3);
        chk("R3 miss first precharge", lc[base], 0);
        chk("R3 miss read addr", la[base+2], 9);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule